// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block predicts whether a conditional branch will be taken, using a table of 2-bit saturating counters selected by the branch's fetch address. Each table slot also carries a valid flag. A slot that has never been trained gives no opinion. The prediction then falls back to a static guess: a branch whose offset is negative (a backward branch, typically a loop) is guessed taken, and a forward branch is guessed not taken.

The front end presents a fetch address and the sign of the branch offset, and reads the prediction in the same cycle. At commit, each resolved branch sends its own address and its real outcome to the training port. The slot is then marked valid and its counter moves one step toward the outcome. The slot is selected by the halfword address, so 16-bit and 32-bit instructions at neighbouring halfwords map to different slots.

Top module: `bimodal_dir_predictor`

## Requirements
- R1: The slot used by both ports is (pc >> 1) modulo ENTRIES. Bit 0 of the address is ignored, and addresses that agree in that value share one slot.
- R2: After reset, every slot is untrained. The prediction then equals `lookup_offset_sign`: 1 (negative offset) gives taken, and 0 gives not taken.
- R3: For a trained slot, `pred_taken` is 1 when the counter is 2 or 3, and 0 when it is 0 or 1, whatever the offset sign.
- R4: A training write marks the slot trained. The first write after the slot was untrained starts from a counter of 0, so it leaves the counter at 1 if the branch was taken and at 0 if it was not.
- R5: A taken outcome adds one to the counter, which stops at 3.
- R6: A not-taken outcome subtracts one from the counter, which stops at 0.
- R7: A training write takes effect at the clock edge. A lookup of the same slot in the same cycle returns the value from before the write.
- R8: While `upd_valid` is 0, `upd_pc` and `upd_taken` change no slot.
- R9: Holding `rst` high at a clock edge marks every slot untrained. Training after that starts again from a counter of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; marks all slots untrained |
| lookup_pc | input | PC_W | Fetch address of the branch to predict |
| lookup_offset_sign | input | 1 | Sign bit of the branch offset, used when the slot is untrained |
| pred_taken | output | 1 | Predicted direction, combinational from the lookup inputs |
| upd_valid | input | 1 | Training write enable for a committed branch |
| upd_pc | input | PC_W | Address of the committed branch |
| upd_taken | input | 1 | Resolved outcome of the committed branch |

## Verification
The bench builds the predictor with ENTRIES=8, PC_W=8 and CTR_W=2. With these values every one of the 256 addresses, with both offset signs, can be looked up in one sweep and compared with an arithmetic model. Only eight slots sit behind those addresses, so aliasing of halfword-distinct addresses, the bit-0 don't-care and both saturation ends are all reached within a short training sequence. The same small table makes it cheap to repeat full sweeps after a reset in mid-run, after masked training traffic, and after a write and a lookup to the same slot in one cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic {
    SRC_STATIC = 1'b0,
    SRC_TABLE  = 1'b1
  } pred_src_e;

  // Backward branches are guessed taken, forward ones not taken.
  function automatic logic static_guess(input logic offset_negative);
    return offset_negative;
  endfunction
endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam bit POW2 = (ENTRIES & (ENTRIES - 1)) == 0;

  generate
    if (POW2) begin : g_slice
      assign idx = pc[IDX_W:1];
      logic unused_bits;
      assign unused_bits = ^{pc[0], pc[PC_W-1:IDX_W+1]};
    end else begin : g_mod
      logic [PC_W-1:0] half;
      assign half = pc >> 1;
      assign idx  = IDX_W'(half % PC_W'(ENTRIES));
    end
  endgenerate
endmodule

// File: rtl/bht_valid_bits.sv
module bht_valid_bits #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_a,
  output logic             rd_b
);
  logic [ENTRIES-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
    end else if (set_en) begin
      vbits[set_idx] <= 1'b1;
    end
  end

  assign rd_a = vbits[rd_a_idx];
  assign rd_b = vbits[rd_b_idx];

  // R9: a reset edge leaves every slot untrained
  assert_reset_clears_R9: assert property (@(posedge clk)
    $past(rst) |-> (vbits == '0));

  // R8: no training write, no change in trained flags
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !set_en |=> $stable(vbits));

  // R4: a training write marks its slot trained
  assert_mark_trained_R4: assert property (@(posedge clk) disable iff (rst)
    set_en |=> vbits[$past(set_idx)]);
endmodule

// File: rtl/bht_counter_store.sv
module bht_counter_store #(
  parameter int ENTRIES = 128,
  parameter int CTR_W   = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CTR_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [CTR_W-1:0] rdata_a,
  output logic [CTR_W-1:0] rdata_b
);
  // No reset on the array: an untrained slot is read as zero by the caller.
  logic [CTR_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R7: the written value is visible from the following cycle on
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/bht_sat_counter.sv
module bht_sat_counter #(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CTR_W-1:0] cur,
  input  logic             taken,
  output logic [CTR_W-1:0] nxt
);
  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] BOT = '0;

  always_comb begin
    nxt = cur;
    if (taken) begin
      if (cur != TOP) nxt = cur + 1'b1;
    end else begin
      if (cur != BOT) nxt = cur - 1'b1;
    end
  end

  // R5: a taken step never goes below the old count, and never wraps
  assert_taken_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (en && taken) |-> (nxt >= cur));

  // R6: a not-taken step never goes above the old count, and never wraps
  assert_nottaken_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !taken) |-> (nxt <= cur));
endmodule

// File: rtl/bimodal_dir_predictor.sv
module bimodal_dir_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 128,
  parameter int CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookup_pc,
  input  logic            lookup_offset_sign,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  import bht_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             lk_trained, up_trained;
  logic [CTR_W-1:0] lk_ctr, up_ctr, up_base, up_next;
  pred_src_e        src;

  bht_index #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lk_index (
    .pc (lookup_pc),
    .idx(lk_idx)
  );

  bht_index #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_up_index (
    .pc (upd_pc),
    .idx(up_idx)
  );

  bht_valid_bits #(.ENTRIES(ENTRIES)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .set_en  (upd_valid),
    .set_idx (up_idx),
    .rd_a_idx(lk_idx),
    .rd_b_idx(up_idx),
    .rd_a    (lk_trained),
    .rd_b    (up_trained)
  );

  bht_counter_store #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (upd_valid),
    .waddr  (up_idx),
    .wdata  (up_next),
    .raddr_a(lk_idx),
    .raddr_b(up_idx),
    .rdata_a(lk_ctr),
    .rdata_b(up_ctr)
  );

  // An untrained slot trains from zero whatever the array holds.
  assign up_base = up_trained ? up_ctr : '0;

  bht_sat_counter #(.CTR_W(CTR_W)) u_step (
    .clk  (clk),
    .rst  (rst),
    .en   (upd_valid),
    .cur  (up_base),
    .taken(upd_taken),
    .nxt  (up_next)
  );

  assign src = lk_trained ? SRC_TABLE : SRC_STATIC;

  always_comb begin
    unique case (src)
      SRC_TABLE:  pred_taken = lk_ctr[CTR_W-1];
      default:    pred_taken = static_guess(lookup_offset_sign);
    endcase
  end

  // R4: the first training of a slot starts from zero
  assert_first_train_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !up_trained) |-> (up_next == {{(CTR_W-1){1'b0}}, upd_taken}));
endmodule

// File: tb/bimodal_dir_predictor_test.sv
`timescale 1ns/1ps
module bimodal_dir_predictor_test;
  localparam int PW = 8;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] lookup_pc;
  logic          lookup_offset_sign;
  logic          pred_taken;
  logic          upd_valid;
  logic [PW-1:0] upd_pc;
  logic          upd_taken;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 0;

  logic       m_trained [NE];
  logic [1:0] m_ctr     [NE];

  always #2 clk = ~clk;

  bimodal_dir_predictor #(.PC_W(PW), .ENTRIES(NE), .CTR_W(2)) uut (
    .clk               (clk),
    .rst               (rst),
    .lookup_pc         (lookup_pc),
    .lookup_offset_sign(lookup_offset_sign),
    .pred_taken        (pred_taken),
    .upd_valid         (upd_valid),
    .upd_pc            (upd_pc),
    .upd_taken         (upd_taken)
  );

  function automatic int slot(input int pc);
    return (pc >> 1) % NE;
  endfunction

  function automatic logic model_pred(input int pc, input logic sgn);
    int s = slot(pc);
    if (!m_trained[s]) return sgn;
    return (m_ctr[s] >= 2);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin
      m_trained[i] = 1'b0;
      m_ctr[i]     = 2'd0;
    end
  endtask

  task automatic model_train(input int pc, input logic tk);
    int s = slot(pc);
    logic [1:0] base = m_trained[s] ? m_ctr[s] : 2'd0;
    if (tk) m_ctr[s] = (base == 2'd3) ? 2'd3 : base + 2'd1;
    else    m_ctr[s] = (base == 2'd0) ? 2'd0 : base - 2'd1;
    m_trained[s] = 1'b1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp, input int pc);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s pc=0x%02h actual=%0b expected=%0b", tag, pc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  // Full lookup sweep over every address and both offset signs.
  task automatic sweep(input string tag);
    for (int pc = 0; pc < (1 << PW); pc++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        lookup_pc          = PW'(pc);
        lookup_offset_sign = s[0];
        #0.5;
        chk(tag, pred_taken, model_pred(pc, s[0]), pc);
      end
    end
  endtask

  task automatic train(input int pc, input logic tk);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc    = PW'(pc);
    upd_taken = tk;
    @(posedge clk);
    model_train(pc, tk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic point(input string tag, input int pc, input logic sgn);
    @(negedge clk);
    lookup_pc          = PW'(pc);
    lookup_offset_sign = sgn;
    #0.5;
    chk(tag, pred_taken, model_pred(pc, sgn), pc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    lookup_pc = '0;
    lookup_offset_sign = 1'b0;
    upd_valid = 1'b0;
    upd_pc = '0;
    upd_taken = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: untrained table follows the offset sign everywhere
    sweep("R2");

    // R4: first training from zero; taken once still predicts not taken
    train(8'h06, 1'b1);
    point("R4", 8'h06, 1'b1);
    point("R4", 8'h06, 1'b0);
    train(8'h0A, 1'b0);
    point("R4", 8'h0A, 1'b1);

    // R1: aliasing and bit-0 don't-care, compared over the whole space
    for (int k = 0; k < 24; k++) train((k * 37 + 5) & 8'hFF, ((k * 5) >> 1) & 1);
    sweep("R1_R3");

    // R5: saturate high, then one decrement still predicts taken
    for (int k = 0; k < 5; k++) train(8'h22, 1'b1);
    point("R5", 8'h23, 1'b0);
    train(8'h32, 1'b0);
    point("R5", 8'h22, 1'b0);
    // R6: saturate low, then one increment still predicts not taken
    for (int k = 0; k < 5; k++) train(8'h22, 1'b0);
    point("R6", 8'h22, 1'b1);
    train(8'h22, 1'b1);
    point("R6", 8'h22, 1'b1);

    // R7: slot at counter 2, same-cycle not-taken write sees the old value
    train(8'h22, 1'b1);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc = 8'h22;
    upd_taken = 1'b0;
    lookup_pc = 8'h22;
    lookup_offset_sign = 1'b0;
    #0.5;
    chk("R7", pred_taken, model_pred(8'h22, 1'b0), 8'h22);
    @(posedge clk);
    model_train(8'h22, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    #0.5;
    chk("R7", pred_taken, model_pred(8'h22, 1'b0), 8'h22);

    // R8: masked training traffic changes nothing
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      upd_valid = 1'b0;
      upd_pc    = PW'(k * 11);
      upd_taken = k[0];
    end
    sweep("R8");

    // R9: mid-run reset, then counters restart from zero
    for (int k = 0; k < 4; k++) train(8'h04, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    sweep("R9");
    train(8'h04, 1'b1);
    point("R9", 8'h04, 1'b0);
    train(8'h05, 1'b1);
    point("R9", 8'h04, 1'b0);

    finish_run();
  end
endmodule